// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several localities owns a shared security-module interface at any moment. Every locality sees its own 4 KB window in the address map. At offset zero of that window sits an 8-bit control byte. Writing it lets a locality ask for ownership, take ownership from a lower-numbered owner, or give ownership up. Reading it returns that locality's view of the arbitration.

The block holds one outstanding-request flag and one taken-away flag per locality, plus a registered owner. It resolves handovers in a single clock. When the owner gives up, the highest-numbered waiting requester is promoted. A higher-numbered locality can also take ownership at once, and the displaced owner is then flagged.

Downstream logic reads the current owner from a valid flag and a 3-bit index. The register port is a plain synchronous one: a write is taken on the clock edge while the write enable is high, and read data follows the address combinationally.

Top module: `loc_arbiter`

## Requirements
- R1: The address is split as locality = addr[14:12] and offset = addr[11:0]. Only offset 0x000 of localities 0..4 holds the control byte. Reads of any other offset, or of localities 5..7, return 0x00, and writes there change nothing.
- R2: A read of the control byte returns the following bits. Bit 7 is always 1, bit 6 is 0, and bit 3 is 0. Bit 5 is set when this locality is the owner. Bit 4 is the taken-away flag. Bit 2 is the waiters flag. Bit 1 is this locality's outstanding request. Bit 0 is always 1. After reset every locality reads 0x81, act_vld is 0 and act_idx is 0.
- R3: Writing bit 1 while no locality owns the interface makes the writer the owner on the next clock edge. No request is left outstanding.
- R4: Writing bit 1 while another locality owns the interface leaves the writer's request outstanding. Writing bit 1 from the owner itself has no effect.
- R5: Bit 2 of a locality reads 1 exactly when at least one other locality has an outstanding request.
- R6: Writing bit 3 from a locality numbered above the current owner makes the writer the owner on the next edge and clears the writer's request. The previous owner loses ownership and its bit 4 becomes 1.
- R7: Writing bit 3 from a locality numbered at or below the owner, or while there is no owner, has no effect.
- R8: Writing 1 to bit 4 clears that locality's taken-away flag. Writing 0 to bit 4 leaves the flag unchanged.
- R9: Writing bit 5 from the owner gives up ownership. The highest-numbered locality with an outstanding request becomes owner and its request clears. If there is no such locality, the interface becomes idle. Writing bit 5 from a non-owner has no effect.
- R10: A single write performs at most one ownership action, chosen in priority order. If bit 5 is set, bits 3 and 1 are ignored. Otherwise, if bit 3 is set, bit 1 is ignored. Written bits 7, 6, 2 and 0 are always ignored.
- R11: act_vld and act_idx are registered and change only on the edge that takes an effective write. act_idx is 0 whenever act_vld is 0 and is always below 5 otherwise.
- R12: rst_n clears all state asynchronously. Its release passes through a two-stage synchronizer before the block responds to writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 15 | Register address: locality field and window offset |
| byte_we | input | 1 | Write strobe for the addressed byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| act_vld | output | 1 | An owner exists |
| act_idx | output | 3 | Index of the owner, 0 when none |

## Verification
The hardest state to reach is one where an owner holds the interface, several localities are queued behind it, and one of them has already been taken from. Only in that state can promotion order, the waiters flag and the taken-away flag be observed together. The stimulus builds it through the register port alone. It grants one locality, queues lower and higher ones, then releases step by step and reads every locality between steps. Further sequences issue seizes from above, from below, from the owner itself and from an idle state. Others combine several command bits in one byte to pin down the action priority.

// File: rtl/lar_pkg.sv
package lar_pkg;
  // control byte bit positions (software decodes these)
  localparam int BIT_OK     = 7;
  localparam int BIT_OWNER  = 5;
  localparam int BIT_TAKEN  = 4;
  localparam int BIT_TAKE   = 3;
  localparam int BIT_WAIT   = 2;
  localparam int BIT_ASK    = 1;
  localparam int BIT_FIXED0 = 0;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_RELEASE,
    ACT_SEIZE,
    ACT_GRANT,
    ACT_QUEUE
  } lar_act_e;
endpackage

// File: rtl/lar_rst_sync.sv
module lar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/lar_decode.sv
module lar_decode
  import lar_pkg::*;
#(
  parameter  int NUM_LOC = 5,
  parameter  int WIN_W   = 12,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int ADDR_W  = LOC_W + WIN_W
) (
  input  logic              byte_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              own_vld,
  input  logic [LOC_W-1:0]  own_idx,
  input  logic [NUM_LOC-1:0] ask_vec,
  output lar_act_e          act,
  output logic [LOC_W-1:0]  tgt,
  output logic              clr_taken,
  output logic              hi_vld,
  output logic [LOC_W-1:0]  hi_idx
);
  logic hit;
  logic is_owner;
  logic unused_bits;

  assign tgt         = addr[ADDR_W-1:WIN_W];
  assign hit         = byte_we && (addr[WIN_W-1:0] == '0) && (int'(tgt) < NUM_LOC);
  assign is_owner    = own_vld && (own_idx == tgt);
  assign clr_taken   = hit && wdata[BIT_TAKEN];
  assign unused_bits = ^{wdata[7:6], wdata[BIT_WAIT], wdata[BIT_FIXED0]};

  // one ownership action per write: release, then seize, then request
  always_comb begin
    act = ACT_NONE;
    if (hit) begin
      if (wdata[BIT_OWNER]) begin
        if (is_owner) act = ACT_RELEASE;
      end else if (wdata[BIT_TAKE]) begin
        if (own_vld && (tgt > own_idx)) act = ACT_SEIZE;
      end else if (wdata[BIT_ASK]) begin
        if (!own_vld)      act = ACT_GRANT;
        else if (!is_owner) act = ACT_QUEUE;
      end
    end
  end

  // highest-numbered outstanding request wins promotion
  always_comb begin
    hi_vld = 1'b0;
    hi_idx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (ask_vec[i]) begin
        hi_vld = 1'b1;
        hi_idx = LOC_W'(i);
      end
    end
  end
endmodule

// File: rtl/lar_owner.sv
module lar_owner
  import lar_pkg::*;
#(
  parameter  int NUM_LOC = 5,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             srst_n,
  input  lar_act_e         act,
  input  logic [LOC_W-1:0] tgt,
  input  logic             hi_vld,
  input  logic [LOC_W-1:0] hi_idx,
  output logic             own_vld,
  output logic [LOC_W-1:0] own_idx
);
  logic             own_en;
  logic             vld_nxt;
  logic [LOC_W-1:0] idx_nxt;

  always_comb begin
    own_en  = 1'b0;
    vld_nxt = own_vld;
    idx_nxt = own_idx;
    unique case (act)
      ACT_RELEASE: begin
        own_en  = 1'b1;
        vld_nxt = hi_vld;
        idx_nxt = hi_vld ? hi_idx : '0;
      end
      ACT_SEIZE, ACT_GRANT: begin
        own_en  = 1'b1;
        vld_nxt = 1'b1;
        idx_nxt = tgt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (own_en) begin
      own_vld <= vld_nxt;
      own_idx <= idx_nxt;
    end
  end
endmodule

// File: rtl/lar_flags.sv
module lar_flags
  import lar_pkg::*;
#(
  parameter  int NUM_LOC = 5,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic               clk,
  input  logic               srst_n,
  input  lar_act_e           act,
  input  logic [LOC_W-1:0]   tgt,
  input  logic               clr_taken,
  input  logic [LOC_W-1:0]   own_idx,
  input  logic               hi_vld,
  input  logic [LOC_W-1:0]   hi_idx,
  output logic [NUM_LOC-1:0] ask_vec,
  output logic [NUM_LOC-1:0] taken_vec
);
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    localparam logic [LOC_W-1:0] MY = LOC_W'(g);
    logic ask_r, ask_set, ask_clr, ask_en;
    logic tkn_r, tkn_set, tkn_clr, tkn_en;

    always_comb begin
      ask_set = (act == ACT_QUEUE) && (tgt == MY);
      ask_clr = ((act == ACT_RELEASE) && hi_vld && (hi_idx == MY)) ||
                ((act == ACT_SEIZE) && (tgt == MY));
      ask_en  = ask_set || ask_clr;
      tkn_set = (act == ACT_SEIZE) && (own_idx == MY);
      tkn_clr = clr_taken && (tgt == MY);
      tkn_en  = tkn_set || tkn_clr;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)     ask_r <= 1'b0;
      else if (ask_en) ask_r <= ask_set;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)     tkn_r <= 1'b0;
      else if (tkn_en) tkn_r <= tkn_set;
    end

    assign ask_vec[g]   = ask_r;
    assign taken_vec[g] = tkn_r;
  end
endmodule

// File: rtl/lar_rdmux.sv
module lar_rdmux
  import lar_pkg::*;
#(
  parameter  int NUM_LOC = 5,
  parameter  int WIN_W   = 12,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int ADDR_W  = LOC_W + WIN_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               own_vld,
  input  logic [LOC_W-1:0]   own_idx,
  input  logic [NUM_LOC-1:0] ask_vec,
  input  logic [NUM_LOC-1:0] taken_vec,
  output logic [7:0]         rdata
);
  logic [LOC_W-1:0] rloc;
  logic             sel;
  logic             others_wait;
  logic             my_ask;
  logic             my_taken;

  assign rloc = addr[ADDR_W-1:WIN_W];
  assign sel  = (addr[WIN_W-1:0] == '0) && (int'(rloc) < NUM_LOC);

  always_comb begin
    others_wait = 1'b0;
    my_ask      = 1'b0;
    my_taken    = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (int'(rloc) == i) begin
        my_ask   = ask_vec[i];
        my_taken = taken_vec[i];
      end else if (ask_vec[i]) begin
        others_wait = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[BIT_OK]     = 1'b1;
      rdata[BIT_OWNER]  = own_vld && (own_idx == rloc);
      rdata[BIT_TAKEN]  = my_taken;
      rdata[BIT_WAIT]   = others_wait;
      rdata[BIT_ASK]    = my_ask;
      rdata[BIT_FIXED0] = 1'b1;
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import lar_pkg::*;
#(
  parameter  int NUM_LOC = 5,
  parameter  int WIN_W   = 12,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int ADDR_W  = LOC_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              act_vld,
  output logic [LOC_W-1:0]  act_idx
);
  logic               rst_sync_n;
  lar_act_e           act;
  logic [LOC_W-1:0]   tgt;
  logic               clr_taken;
  logic               hi_vld;
  logic [LOC_W-1:0]   hi_idx;
  logic [NUM_LOC-1:0] ask_vec;
  logic [NUM_LOC-1:0] taken_vec;

  lar_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (rst_sync_n)
  );

  lar_decode #(.NUM_LOC(NUM_LOC), .WIN_W(WIN_W)) u_dec (
    .byte_we   (byte_we),
    .addr      (addr),
    .wdata     (wdata),
    .own_vld   (act_vld),
    .own_idx   (act_idx),
    .ask_vec   (ask_vec),
    .act       (act),
    .tgt       (tgt),
    .clr_taken (clr_taken),
    .hi_vld    (hi_vld),
    .hi_idx    (hi_idx)
  );

  lar_owner #(.NUM_LOC(NUM_LOC)) u_own (
    .clk     (clk),
    .srst_n  (rst_sync_n),
    .act     (act),
    .tgt     (tgt),
    .hi_vld  (hi_vld),
    .hi_idx  (hi_idx),
    .own_vld (act_vld),
    .own_idx (act_idx)
  );

  lar_flags #(.NUM_LOC(NUM_LOC)) u_flg (
    .clk       (clk),
    .srst_n    (rst_sync_n),
    .act       (act),
    .tgt       (tgt),
    .clr_taken (clr_taken),
    .own_idx   (act_idx),
    .hi_vld    (hi_vld),
    .hi_idx    (hi_idx),
    .ask_vec   (ask_vec),
    .taken_vec (taken_vec)
  );

  lar_rdmux #(.NUM_LOC(NUM_LOC), .WIN_W(WIN_W)) u_rd (
    .addr      (addr),
    .own_vld   (act_vld),
    .own_idx   (act_idx),
    .ask_vec   (ask_vec),
    .taken_vec (taken_vec),
    .rdata     (rdata)
  );
endmodule

// File: rtl/lar_chk.sv
module lar_chk #(
  parameter  int NUM_LOC = 5,
  parameter  int WIN_W   = 12,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int ADDR_W  = LOC_W + WIN_W
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              byte_we,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              act_vld,
  input logic [LOC_W-1:0]  act_idx
);
  logic [LOC_W-1:0] loc;
  logic             at_ctl;
  logic             wr_hit;

  assign loc    = addr[ADDR_W-1:WIN_W];
  assign at_ctl = (addr[WIN_W-1:0] == '0) && (int'(loc) < NUM_LOC);
  assign wr_hit = byte_we && at_ctl;

  // R11
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !act_vld |-> act_idx == '0);

  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    act_vld |-> int'(act_idx) < NUM_LOC);

  // R1
  quiet_owner_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_hit |=> $stable(act_vld) && $stable(act_idx));

  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_hit && !wdata[5] && !wdata[3] && wdata[1] && !act_vld)
    |=> act_vld && act_idx == $past(loc));

  // R6
  seize_up_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_hit && !wdata[5] && wdata[3] && act_vld && loc > act_idx)
    |=> act_vld && act_idx == $past(loc));

  // R7
  seize_blocked_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_hit && !wdata[5] && wdata[3] && (!act_vld || loc <= act_idx))
    |=> $stable(act_vld) && $stable(act_idx));

  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!srst_n)
    at_ctl |-> rdata[7] && rdata[0] && !rdata[6] && !rdata[3]);

  // R1
  outside_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !at_ctl |-> rdata == 8'h00);
endmodule

bind loc_arbiter lar_chk #(.NUM_LOC(NUM_LOC), .WIN_W(WIN_W)) chk_i (
  .clk     (clk),
  .srst_n  (rst_sync_n),
  .addr    (addr),
  .byte_we (byte_we),
  .wdata   (wdata),
  .rdata   (rdata),
  .act_vld (act_vld),
  .act_idx (act_idx)
);

// File: tb/loc_arbiter_tb_top.sv
module loc_arbiter_tb_top;
  localparam int CLK_P  = 10;
  localparam int WIN_W  = 12;
  localparam int LOC_W  = 3;
  localparam int ADDR_W = LOC_W + WIN_W;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              byte_we;
  logic [7:0]        wdata;
  logic [7:0]        rdata;
  logic              act_vld;
  logic [LOC_W-1:0]  act_idx;

  int total;
  int bad;

  loc_arbiter dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .byte_we (byte_we),
    .wdata   (wdata),
    .rdata   (rdata),
    .act_vld (act_vld),
    .act_idx (act_idx)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  function automatic logic [ADDR_W-1:0] mk(int loc, int off);
    return ADDR_W'((loc << WIN_W) + off);
  endfunction

  task automatic wr(int loc, int off, logic [7:0] d);
    @(negedge clk);
    addr    = mk(loc, off);
    wdata   = d;
    byte_we = 1'b1;
    @(negedge clk);
    byte_we = 1'b0;
    wdata   = 8'h00;
  endtask

  task automatic see(int loc, int off, logic [7:0] exp, string tag);
    logic [7:0] v;
    @(negedge clk);
    addr = mk(loc, off);
    #1 v = rdata;
    total++;
    if (v !== exp) begin
      bad++;
      $display("FAIL %s: loc %0d off 0x%0h actual=0x%02h expected=0x%02h",
               tag, loc, off, v, exp);
    end
  endtask

  task automatic see_own(logic vld, int idx, string tag);
    logic [LOC_W:0] v;
    @(negedge clk);
    v = {act_vld, act_idx};
    total++;
    if (v !== {vld, LOC_W'(idx)}) begin
      bad++;
      $display("FAIL %s: owner actual=%0b/%0d expected=%0b/%0d",
               tag, v[LOC_W], v[LOC_W-1:0], vld, idx);
    end
  endtask

  task automatic t_reset();
    see_own(1'b0, 0, "R2 reset owner");
    for (int l = 0; l < 5; l++) see(l, 0, 8'h81, "R2 reset byte");
  endtask

  task automatic t_map();
    wr(1, 'h004, 8'h02);
    see_own(1'b0, 0, "R1 other offset write");
    see(1, 0, 8'h81, "R1 other offset no request");
    wr(6, 0, 8'h02);
    see_own(1'b0, 0, "R1 locality 6 write");
    see(7, 0, 8'h00, "R1 locality 7 read");
    see(2, 'h018, 8'h00, "R1 other offset read");
  endtask

  task automatic t_idle_grant();
    wr(2, 0, 8'h02);
    see_own(1'b1, 2, "R3 idle grant owner");
    see(2, 0, 8'hA1, "R3 idle grant byte");
    wr(2, 0, 8'h02);
    see(2, 0, 8'hA1, "R4 owner request ignored");
    wr(2, 0, 8'h20);
    see_own(1'b0, 0, "R9 release to idle");
    see(2, 0, 8'h81, "R9 release byte");
  endtask

  task automatic t_queue();
    wr(1, 0, 8'h02);
    wr(0, 0, 8'h02);
    see(0, 0, 8'h83, "R4 queued alone");
    see(1, 0, 8'hA5, "R5 owner sees waiter");
    wr(3, 0, 8'h02);
    see(0, 0, 8'h87, "R5 waiter sees other waiter");
    see(3, 0, 8'h87, "R4 second queued");
    wr(2, 0, 8'h20);
    see_own(1'b1, 1, "R9 non-owner release ignored");
    wr(1, 0, 8'h20);
    see_own(1'b1, 3, "R9 highest promoted");
    see(3, 0, 8'hA5, "R9 promoted request cleared");
    see(0, 0, 8'h83, "R5 no other waiter");
    wr(3, 0, 8'h20);
    see_own(1'b1, 0, "R9 next promoted");
    see(0, 0, 8'hA1, "R9 last promoted byte");
    wr(0, 0, 8'h20);
    see_own(1'b0, 0, "R9 queue drained");
  endtask

  task automatic t_seize();
    wr(1, 0, 8'h02);
    wr(0, 0, 8'h08);
    see_own(1'b1, 1, "R7 lower seize");
    see(0, 0, 8'h81, "R7 lower seize byte");
    wr(1, 0, 8'h08);
    see_own(1'b1, 1, "R7 own seize");
    wr(3, 0, 8'h02);
    wr(3, 0, 8'h08);
    see_own(1'b1, 3, "R6 seize up owner");
    see(3, 0, 8'hA1, "R6 seizer request cleared");
    see(1, 0, 8'h91, "R6 previous owner taken");
    wr(4, 0, 8'h08);
    see_own(1'b1, 4, "R6 seize without request");
    see(3, 0, 8'h91, "R6 second taken flag");
    wr(1, 0, 8'h00);
    see(1, 0, 8'h91, "R8 zero leaves flag");
    wr(1, 0, 8'h10);
    see(1, 0, 8'h81, "R8 one clears flag");
    see(3, 0, 8'h91, "R8 other flag kept");
    wr(3, 0, 8'h10);
    wr(4, 0, 8'h20);
    see_own(1'b0, 0, "R9 release after seize");
    wr(2, 0, 8'h08);
    see_own(1'b0, 0, "R7 seize while idle");
    see(2, 0, 8'h81, "R7 idle seize byte");
  endtask

  task automatic t_priority();
    wr(1, 0, 8'h02);
    wr(2, 0, 8'h02);
    wr(1, 0, 8'h2A);
    see_own(1'b1, 2, "R10 release beats seize and request");
    see(1, 0, 8'h81, "R10 request dropped on release");
    wr(3, 0, 8'h0A);
    see_own(1'b1, 3, "R10 seize beats request");
    see(3, 0, 8'hA1, "R10 no request left");
    see(2, 0, 8'h91, "R10 seized flag");
    wr(0, 0, 8'hC5);
    see_own(1'b1, 3, "R10 ignored bits owner");
    see(0, 0, 8'h81, "R10 ignored bits byte");
    wr(2, 0, 8'h10);
    wr(3, 0, 8'h20);
    see_own(1'b0, 0, "R10 cleanup idle");
  endtask

  task automatic t_async_reset();
    logic v;
    wr(2, 0, 8'h02);
    wr(0, 0, 8'h02);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 v = act_vld;
    total++;
    if (v !== 1'b0) begin
      bad++;
      $display("FAIL R12 async clear: actual=%0b expected=0", v);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(3, 0, 8'h02);
    see_own(1'b0, 0, "R12 write during sync ignored");
    repeat (3) @(negedge clk);
    see(0, 0, 8'h81, "R12 request cleared");
    wr(3, 0, 8'h02);
    see_own(1'b1, 3, "R12 live after sync");
  endtask

  initial begin
    total   = 0;
    bad     = 0;
    rst_n   = 1'b0;
    addr    = '0;
    byte_we = 1'b0;
    wdata   = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_idle_grant();
    t_queue();
    t_seize();
    t_priority();
    t_async_reset();
    summary();
    $finish;
  end
endmodule